// File: doc/BRIEF.md
# Debug Halt Request Controller

This block decides the cycle in which a processor core is stopped and handed to debug mode. Each cycle the core reports whether an instruction retired normally, whether one was aborted, and whether the retiring instruction matched a program-fetch breakpoint or a data-access breakpoint. The address comparators that raise those flags sit outside the block. The block keeps two down-counters. The step counter supports single-step and N-step tracing. The hit counter lets a chosen number of breakpoint matches go by before one of them stops the core.

When a stop condition holds, the block raises a one-cycle debug request and latches the cause bits. It then stays frozen until the debugger strobes resume. A fetch breakpoint stops the core right after the matching instruction retires. A data breakpoint stops the core only after the next retired instruction. Aborted instructions never count. A small write port loads the enables and both counters.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: After reset, dbg_req_o, halted_o and cause_o are 0, both enables are off, and both counters and the pending data flag are 0.
- R2: With stepping enabled, each retired instruction decrements a nonzero step count. A retirement while the count is 0 stops the core, so a loaded count N stops the core on the (N+1)th retirement.
- R3: A cycle with insn_abort_i high is ignored entirely. It changes no counter, counts no breakpoint, does not advance a pending data flag and raises no request. Abort overrides insn_done_i.
- R4: With breakpoints enabled and the hit count at 0, a retirement flagged with fetch_bp_i stops the core on that same retirement.
- R5: A breakpoint match on a retirement while the hit count is nonzero decrements the count and does not stop the core.
- R6: A data_bp_i match at hit count 0 sets a pending flag, and the core stops on the next retired instruction. When fetch_bp_i and data_bp_i both match at count 0, the fetch rule applies and nothing is left pending.
- R7: When stepping and breakpoint conditions meet on one retirement, a single request is issued. cause_o bit 0 marks the step cause and bit 1 marks the breakpoint cause.
- R8: dbg_req_o is high for exactly the one cycle after the stopping retirement. halted_o then stays high, and retirements and matches are ignored until resume_i.
- R9: Register writes take effect on the next clock. Address 0 is the control register, with bit 0 enabling stepping and bit 1 enabling breakpoints. Address 1 is the step count and address 2 is the hit count. A write to address 0 or 2 clears the pending data flag.
- R10: resume_i while halted clears halted_o and cause_o on the next clock. resume_i while running has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| insn_done_i | input | 1 | An instruction retired this cycle |
| insn_abort_i | input | 1 | An instruction was aborted this cycle |
| fetch_bp_i | input | 1 | Retiring instruction matched a fetch breakpoint |
| data_bp_i | input | 1 | Retiring instruction matched a data-access breakpoint |
| resume_i | input | 1 | Leave debug mode |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | CNT_W | Write data |
| dbg_req_o | output | 1 | One-cycle debug entry request |
| halted_o | output | 1 | Core is held in debug mode |
| cause_o | output | 2 | Latched stop cause, bit 0 step, bit 1 breakpoint |

## Verification
A step or hit counter that is off by one moves the request by whole retirements. That error shows at dbg_req_o as an early or late pulse on the very retirement in question. A pending data flag that is lost or kept too long shows the same way, one retirement after the access. A freeze that fails turns dbg_req_o into a second pulse while halted_o is high. Wrong cause latching is visible on cause_o in the cycle of the request and stays visible until resume.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;
  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_STEP  = 2'd1,
    REG_HITS  = 2'd2,
    REG_NONE  = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_STEP_BIT = 0;
  localparam int unsigned CTRL_BRK_BIT  = 1;
  localparam int unsigned CAUSE_STEP    = 0;
  localparam int unsigned CAUSE_BRK     = 1;
  localparam int unsigned CAUSE_W       = 2;
endpackage

// File: rtl/dbg_step_unit.sv
module dbg_step_unit #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic             freeze_i,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             stop_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             active;
  logic             zero;

  assign active = retire_i & ~freeze_i & en_i;
  assign zero   = (cnt_q == '0);
  assign stop_o = active & zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (wr_i)           cnt_q <= wdata_i;
    else if (active && !zero) cnt_q <= cnt_q - CNT_W'(1);
  end

  AST_STEP_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !zero && !wr_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R2
  AST_STEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && !wr_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             retire_i,
  input  logic             freeze_i,
  input  logic             en_i,
  input  logic             fetch_i,
  input  logic             data_i,
  input  logic             wr_cnt_i,
  input  logic             clr_pend_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             stop_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             live;
  logic             hit;
  logic             zero;
  logic             fetch_stop;
  logic             data_stop;

  assign live       = retire_i & ~freeze_i;
  assign hit        = live & en_i & (fetch_i | data_i);
  assign zero       = (cnt_q == '0);
  assign fetch_stop = hit & zero & fetch_i;
  assign data_stop  = live & pend_q;
  assign stop_o     = fetch_stop | data_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (wr_cnt_i)       cnt_q <= wdata_i;
    else if (hit && !zero)   cnt_q <= cnt_q - CNT_W'(1);
  end

  // pending data match survives exactly one further retirement
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         pend_q <= 1'b0;
    else if (clr_pend_i) pend_q <= 1'b0;
    else if (live)       pend_q <= ~pend_q & hit & zero & data_i & ~fetch_i;
  end

  AST_HIT_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !zero && !wr_cnt_i) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
  AST_PEND_ONE_INSN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && live) |=> !pend_q); // R6
  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!retire_i && !clr_pend_i) |=> $stable(pend_q)); // R3
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
  import dbg_halt_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               insn_done_i,
  input  logic               insn_abort_i,
  input  logic               fetch_bp_i,
  input  logic               data_bp_i,
  input  logic               resume_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [CNT_W-1:0]   reg_wdata_i,
  output logic               dbg_req_o,
  output logic               halted_o,
  output logic [CAUSE_W-1:0] cause_o
);
  logic     retire;
  logic     step_en_q, brk_en_q;
  logic     wr_ctrl, wr_step, wr_hits;
  logic     step_stop, brk_stop, any_stop;
  reg_sel_e sel;

  assign sel     = reg_sel_e'(reg_addr_i);
  assign retire  = insn_done_i & ~insn_abort_i;
  assign wr_ctrl = reg_we_i & (sel == REG_CTRL);
  assign wr_step = reg_we_i & (sel == REG_STEP);
  assign wr_hits = reg_we_i & (sel == REG_HITS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_en_q <= 1'b0;
      brk_en_q  <= 1'b0;
    end else if (wr_ctrl) begin
      step_en_q <= reg_wdata_i[CTRL_STEP_BIT];
      brk_en_q  <= reg_wdata_i[CTRL_BRK_BIT];
    end
  end

  dbg_step_unit #(.CNT_W(CNT_W)) u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .retire_i (retire),
    .freeze_i (halted_o),
    .en_i     (step_en_q),
    .wr_i     (wr_step),
    .wdata_i  (reg_wdata_i),
    .stop_o   (step_stop)
  );

  dbg_brk_unit #(.CNT_W(CNT_W)) u_brk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .retire_i   (retire),
    .freeze_i   (halted_o),
    .en_i       (brk_en_q),
    .fetch_i    (fetch_bp_i),
    .data_i     (data_bp_i),
    .wr_cnt_i   (wr_hits),
    .clr_pend_i (wr_ctrl | wr_hits),
    .wdata_i    (reg_wdata_i),
    .stop_o     (brk_stop)
  );

  assign any_stop = step_stop | brk_stop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_req_o <= 1'b0;
      halted_o  <= 1'b0;
      cause_o   <= '0;
    end else begin
      dbg_req_o <= any_stop;
      if (any_stop) begin
        halted_o            <= 1'b1;
        cause_o[CAUSE_STEP] <= step_stop;
        cause_o[CAUSE_BRK]  <= brk_stop;
      end else if (halted_o && resume_i) begin
        halted_o <= 1'b0;
        cause_o  <= '0;
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_req_o |=> !dbg_req_o); // R8
  AST_REQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_req_o |-> (halted_o && cause_o != '0)); // R7
  AST_ABORT_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    insn_abort_i |=> !dbg_req_o); // R3
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !resume_i) |=> (halted_o && $stable(cause_o))); // R8
  AST_RESUME_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && resume_i) |=> (!halted_o && cause_o == '0)); // R10
endmodule

// File: tb/dbg_halt_ctrl_tb.sv
module dbg_halt_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int NROWS      = 13;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             done, abrt, fbp, dbp, res, we;
  logic [1:0]       addr;
  logic [CNT_W-1:0] wdata;
  logic             req, halted;
  logic [1:0]       cause;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_halt_ctrl #(.CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .insn_done_i(done), .insn_abort_i(abrt),
    .fetch_bp_i(fbp), .data_bp_i(dbp), .resume_i(res), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .dbg_req_o(req),
    .halted_o(halted), .cause_o(cause)
  );

  // {done, abort, fetch, data, resume, exp_req, exp_halted, exp_cause[1:0]}
  // preload: control=3, step count=3, hit count=1
  localparam logic [8:0] VEC [NROWS] = '{
    9'b10000_0_0_00, // step 3->2
    9'b01100_0_0_00, // aborted with fetch match: ignored
    9'b10100_0_0_00, // hits 1->0, step 2->1
    9'b10000_0_0_00, // step 1->0
    9'b10100_1_1_11, // both causes on one retirement
    9'b00000_0_1_11,
    9'b10000_0_1_11, // frozen
    9'b00001_0_0_00, // resume
    9'b10010_1_1_01, // step stop, data match goes pending
    9'b00001_0_0_00,
    9'b01000_0_0_00, // abort keeps pending
    9'b10000_1_1_11, // step + pending data
    9'b00001_0_0_00
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act{req,halt,cause}=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic d, a, f, dp, r, input logic [3:0] exp, input string tag);
    @(negedge clk);
    done = d; abrt = a; fbp = f; dbp = dp; res = r; we = 1'b0;
    @(posedge clk); #1;
    check(tag, {req, halted, cause}, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] v);
    @(negedge clk);
    done = 0; abrt = 0; fbp = 0; dbp = 0; res = 0;
    we = 1'b1; addr = a; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    done = 0; abrt = 0; fbp = 0; dbp = 0; res = 0; we = 0; addr = 0; wdata = 0;
    #(CLK_PERIOD * 3);
    check("R1 reset", {req, halted, cause}, 4'b0000);
    rst_n = 1'b1;
    step(1, 0, 1, 1, 0, 4'b0000, "R1 enables off after reset");

    wr(2'd0, 8'd3); wr(2'd1, 8'd3); wr(2'd2, 8'd1);
    for (int i = 0; i < NROWS; i++) begin
      step(VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3:0],
           $sformatf("R2/R3/R4/R5/R6/R7/R8 row %0d", i));
    end

    // R6 data match alone, stepping off
    wr(2'd0, 8'd2);
    step(1, 0, 0, 1, 0, 4'b0000, "R6 data match no stop yet");
    step(0, 1, 0, 0, 0, 4'b0000, "R3 abort does not advance pending");
    step(0, 0, 0, 0, 0, 4'b0000, "R6 idle");
    step(1, 0, 0, 0, 0, 4'b1110, "R6 stop after next retirement");
    step(0, 0, 0, 0, 1, 4'b0000, "R10 resume");

    // R9 control write clears pending
    step(1, 0, 0, 1, 0, 4'b0000, "R9 arm pending");
    wr(2'd0, 8'd2);
    step(1, 0, 0, 0, 0, 4'b0000, "R9 pending cleared by write");

    // R2 N-step
    wr(2'd1, 8'd2); wr(2'd0, 8'd1);
    step(1, 0, 0, 0, 0, 4'b0000, "R2 step 1");
    step(1, 0, 0, 0, 0, 4'b0000, "R2 step 2");
    step(1, 0, 0, 0, 0, 4'b1101, "R2 stop on third");
    step(0, 0, 0, 0, 0, 4'b0101, "R8 pulse ends");
    step(0, 0, 0, 0, 1, 4'b0000, "R10 resume");
    step(0, 0, 0, 0, 1, 4'b0000, "R10 resume while running");

    // R5 hit count 2, fetch only
    wr(2'd0, 8'd2); wr(2'd2, 8'd2);
    step(1, 0, 1, 0, 0, 4'b0000, "R5 hit 1 counted");
    step(1, 0, 1, 0, 0, 4'b0000, "R5 hit 2 counted");
    step(1, 0, 1, 0, 0, 4'b1110, "R4 fetch stop at zero");
    step(0, 0, 0, 0, 1, 4'b0000, "R10 resume");

    // R6 fetch and data together: no pending left
    step(1, 0, 1, 1, 0, 4'b1110, "R6 fetch wins");
    step(0, 0, 0, 0, 1, 4'b0000, "R10 resume");
    step(1, 0, 0, 0, 0, 4'b0000, "R6 nothing pending");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule